// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block receives characters from an asynchronous serial line. It takes the line from an external pin or from an internal loopback source, can invert the line's polarity, and samples it at sixteen times the bit rate. A 13-bit divisor sets that rate from the system clock. Each bit is decided by a majority vote over three samples taken near its middle. A completed character of 8 or 9 data bits is copied into a read-only holding register. The ninth bit, when present, is kept in its own output bit.

Eight status flags report the outcome of each reception: data ready, overrun, noise, framing error, parity error, idle line, break and line activity. Software clears any flag by writing a one to its bit in a clear vector. Each flag has its own interrupt enable, and the enabled flags are ORed into a single registered interrupt request.

Top module: `uart_rx_flags`

## Requirements
- R1: Frames are sent LSB first as one low start bit, 8 data bits and one stop bit. When a frame completes and flag bit 0 (ready) is clear, the data appears on `rx_data` and ready is set.
- R2: When `mode9` is 1, a frame carries 9 data bits and the ninth is stored on `rx_bit8`. When `mode9` is 0, `rx_bit8` is stored as 0.
- R3: Each bit is the majority of samples 7, 8 and 9 out of the 16 samples in that bit. If any bit of a stored frame had samples that disagree, flag bit 2 (noise) is set.
- R4: When `par_en` is 1, the last data position is a parity bit. If the XOR of all data bits differs from `par_odd` (0 = even, 1 = odd), flag bit 4 is set.
- R5: A stop bit that samples low sets flag bit 3 (framing error). The frame is still stored.
- R6: A frame whose start, data and stop bits are all low sets flag bit 6 (break) together with the framing error.
- R7: A frame that completes while ready is set sets flag bit 1 (overrun). The new frame is dropped, and `rx_data` and `rx_bit8` keep their old values.
- R8: Flag bit 5 (idle) is set once after a reception, when the line has then stayed high for one full frame time (frame bits × 16 sample ticks).
- R9: A falling edge on the conditioned line sets flag bit 7 (activity). This happens at any time, whether or not sample ticks are running.
- R10: `rx_inv` inverts the incoming line. When `lb_en` is 1, the line is taken from `lb_txd` and `rx_pin` has no effect.
- R11: A sample tick occurs once every `baud_div` clocks. When `baud_div` is 0, ticks stop and no frame is received.
- R12: Writing a one to bit n of `flag_clr` clears flag n and leaves the other flags unchanged. A flag being set in the same cycle wins over the clear.
- R13: `irq` equals the OR of `flags & irq_en` from the previous cycle.
- R14: After synchronous reset, `flags`, `rx_data`, `rx_bit8` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin | input | 1 | External serial line |
| lb_txd | input | 1 | Internal loopback source |
| lb_en | input | 1 | Take the line from the loopback source |
| rx_inv | input | 1 | Invert the line polarity |
| mode9 | input | 1 | 9-bit characters when set |
| par_en | input | 1 | Parity checking enable |
| par_odd | input | 1 | Parity type: 1 odd, 0 even |
| baud_div | input | 13 | Clocks per sample tick; 0 stops reception |
| flag_clr | input | 8 | Write-one-to-clear strobe for each flag |
| irq_en | input | 8 | Interrupt enable for each flag |
| rx_data | output | 8 | Received data, low 8 bits |
| rx_bit8 | output | 1 | Ninth received data bit |
| flags | output | 8 | Status flags, bit positions as listed in the requirements |
| irq | output | 1 | Registered interrupt request |

## Verification
The line passes through two synchronizer stages before the receiver sees it. A bit is decided at its ninth sample, and the frame completes at the stop bit's ninth sample. The flags and the holding register take the result one clock later, and `irq` follows the flags by one more clock. The activity flag is due about four clocks after the line falls, and idle comes one full frame time after the stop decision. Because of this, the bench samples results on falling clock edges, four clocks after the last stop bit ends. For a noise test, it places a one-clock glitch exactly on the eighth sample of a chosen bit. Idle is checked only after twelve bit times at the active divisor.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam int FLAG_W   = 8;
  localparam int DATA_MAX = 9;
  localparam int SR_W     = DATA_MAX + 2;

  localparam int F_RDY = 0;
  localparam int F_OVR = 1;
  localparam int F_NSE = 2;
  localparam int F_FRM = 3;
  localparam int F_PAR = 4;
  localparam int F_IDL = 5;
  localparam int F_BRK = 6;
  localparam int F_EDG = 7;

  typedef struct packed {
    logic [DATA_MAX-1:0] data;
    logic                noise;
    logic                frm;
    logic                par;
    logic                brk;
  } frame_res_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/urx_baud_gen.sv
module urx_baud_gen #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div - DIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

  // R11: ticks are spaced by the divisor
  p_tick_gap_r11: assert property (@(posedge clk) disable iff (rst)
    (tick && div > DIV_W'(1) && $stable(div)) |=> !tick);
  // R11: zero divisor halts ticks
  p_tick_halt_r11: assert property (@(posedge clk) disable iff (rst)
    (div == '0) |=> !tick);
endmodule

// File: rtl/urx_line_front.sv
module urx_line_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic lb_txd,
  input  logic lb_en,
  input  logic inv,
  output logic line,
  output logic edge_p
);
  logic                   raw;
  logic [SYNC_STAGES-1:0] sync;
  logic                   prev;

  assign raw = (lb_en ? lb_txd : pin) ^ inv;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync <= '1;
        else     sync <= {sync[SYNC_STAGES-2:0], raw};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync <= '1;
        else     sync <= raw;
      end
    end
  endgenerate

  assign line = sync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= 1'b1;
      edge_p <= 1'b0;
    end else begin
      prev   <= line;
      edge_p <= prev & ~line;
    end
  end
endmodule

// File: rtl/urx_frame_fsm.sv
module urx_frame_fsm
  import urx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line,
  input  logic       mode9,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       done,
  output frame_res_t res,
  output logic       idle_p
);
  localparam int CNT_W  = $clog2(OVS);
  localparam int BIT_W  = $clog2(SR_W + 1);
  localparam int IDLE_W = $clog2(SR_W * OVS + 1);
  localparam int SMP_A  = OVS / 2 - 1;
  localparam int SMP_B  = OVS / 2;
  localparam int SMP_C  = OVS / 2 + 1;

  typedef enum logic {S_IDLE, S_RECV} st_t;

  st_t                 state;
  logic [CNT_W-1:0]    smp;
  logic [BIT_W-1:0]    bit_idx;
  logic                s_a, s_b;
  logic [SR_W-1:0]     sr;
  logic                nacc;
  logic [IDLE_W-1:0]   idle_cnt;
  logic                idle_arm;

  logic                maj, dis, brk_c, pe_c;
  logic [SR_W-1:0]     sr_nxt;
  logic [DATA_MAX-1:0] dat_c;
  logic [BIT_W-1:0]    stop_idx;
  logic [IDLE_W-1:0]   frame_ticks;

  always_comb begin
    maj         = maj3(s_a, s_b, line);
    dis         = !((s_a == s_b) && (s_b == line));
    sr_nxt      = {maj, sr[SR_W-1:1]};
    stop_idx    = mode9 ? BIT_W'(SR_W - 1) : BIT_W'(SR_W - 2);
    frame_ticks = mode9 ? IDLE_W'(SR_W * OVS) : IDLE_W'((SR_W - 1) * OVS);
    dat_c       = mode9 ? sr_nxt[SR_W-2:1] : {1'b0, sr_nxt[SR_W-2:2]};
    brk_c       = mode9 ? (sr_nxt == '0) : (sr_nxt[SR_W-1:1] == '0);
    pe_c        = par_en && ((^dat_c) != par_odd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      smp      <= '0;
      bit_idx  <= '0;
      s_a      <= 1'b1;
      s_b      <= 1'b1;
      sr       <= '0;
      nacc     <= 1'b0;
      done     <= 1'b0;
      res      <= '0;
      idle_cnt <= '0;
      idle_arm <= 1'b0;
      idle_p   <= 1'b0;
    end else begin
      done   <= 1'b0;
      idle_p <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            if (!line) begin
              state    <= S_RECV;
              smp      <= CNT_W'(1);
              bit_idx  <= '0;
              sr       <= '0;
              nacc     <= 1'b0;
              idle_cnt <= '0;
              idle_arm <= 1'b1;
            end else if (idle_arm) begin
              if (idle_cnt == frame_ticks - IDLE_W'(1)) begin
                idle_p   <= 1'b1;
                idle_arm <= 1'b0;
                idle_cnt <= '0;
              end else begin
                idle_cnt <= idle_cnt + IDLE_W'(1);
              end
            end
          end
          S_RECV: begin
            if (smp == CNT_W'(OVS - 1)) begin
              smp     <= '0;
              bit_idx <= bit_idx + BIT_W'(1);
            end else begin
              smp <= smp + CNT_W'(1);
            end
            if (smp == CNT_W'(SMP_A)) s_a <= line;
            if (smp == CNT_W'(SMP_B)) s_b <= line;
            if (smp == CNT_W'(SMP_C)) begin
              if (bit_idx == '0 && maj) begin
                state <= S_IDLE;
              end else begin
                sr   <= sr_nxt;
                nacc <= nacc | dis;
                if (bit_idx == stop_idx) begin
                  state     <= S_IDLE;
                  done      <= 1'b1;
                  res.data  <= dat_c;
                  res.noise <= nacc | dis;
                  res.frm   <= ~maj;
                  res.par   <= pe_c;
                  res.brk   <= brk_c;
                  idle_cnt  <= '0;
                end
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R1: a completed frame returns the receiver to the idle state
  p_done_idle_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> state == S_IDLE);
  // R6: a break always carries a framing error
  p_brk_frm_r6: assert property (@(posedge clk) disable iff (rst)
    (done && res.brk) |-> res.frm);
  // R8: idle is reported only while waiting for a start bit
  p_idle_wait_r8: assert property (@(posedge clk) disable iff (rst)
    idle_p |-> state == S_IDLE);
  // R2: in 8-bit mode the ninth bit of a completed frame is zero
  p_bit8_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (done && $past(!mode9) && !mode9) |-> !res.data[DATA_MAX-1]);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import urx_pkg::*;
#(
  parameter int DIV_W       = 13,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_pin,
  input  logic              lb_txd,
  input  logic              lb_en,
  input  logic              rx_inv,
  input  logic              mode9,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [FLAG_W-1:0] flag_clr,
  input  logic [FLAG_W-1:0] irq_en,
  output logic [7:0]        rx_data,
  output logic              rx_bit8,
  output logic [FLAG_W-1:0] flags,
  output logic              irq
);
  logic              tick, line, edge_p, done, idle_p, ovr;
  frame_res_t        res;
  logic [FLAG_W-1:0] set_v, flags_nxt;

  urx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .div(baud_div), .tick(tick)
  );

  urx_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .pin(rx_pin), .lb_txd(lb_txd), .lb_en(lb_en),
    .inv(rx_inv), .line(line), .edge_p(edge_p)
  );

  urx_frame_fsm #(.OVS(OVS)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick), .line(line), .mode9(mode9),
    .par_en(par_en), .par_odd(par_odd), .done(done), .res(res),
    .idle_p(idle_p)
  );

  always_comb begin
    ovr          = done && flags[F_RDY] && !flag_clr[F_RDY];
    set_v        = '0;
    set_v[F_RDY] = done && !ovr;
    set_v[F_OVR] = ovr;
    set_v[F_NSE] = done && !ovr && res.noise;
    set_v[F_FRM] = done && !ovr && res.frm;
    set_v[F_PAR] = done && !ovr && res.par;
    set_v[F_BRK] = done && !ovr && res.brk;
    set_v[F_IDL] = idle_p;
    set_v[F_EDG] = edge_p;
    flags_nxt    = (flags & ~flag_clr) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      rx_data <= '0;
      rx_bit8 <= 1'b0;
      irq     <= 1'b0;
    end else begin
      flags <= flags_nxt;
      irq   <= |(flags & irq_en);
      if (done && !ovr) begin
        rx_data <= res.data[7:0];
        rx_bit8 <= res.data[DATA_MAX-1];
      end
    end
  end

  // R1: a frame taken into a free register raises ready
  p_ready_set_r1: assert property (@(posedge clk) disable iff (rst)
    (done && !flags[F_RDY]) |=> flags[F_RDY]);
  // R7: overrun keeps the old data and sets its flag
  p_ovr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (done && flags[F_RDY] && !flag_clr[F_RDY]) |=> (flags[F_OVR] && $stable(rx_data) && $stable(rx_bit8)));
  // R9: a line fall is recorded
  p_edge_flag_r9: assert property (@(posedge clk) disable iff (rst)
    edge_p |=> flags[F_EDG]);
  // R12: a clear with no competing set empties the flag
  p_clr_noise_r12: assert property (@(posedge clk) disable iff (rst)
    (flag_clr[F_NSE] && !done) |=> !flags[F_NSE]);
  // R13: an enabled flag raises the request one cycle later
  p_irq_follow_r13: assert property (@(posedge clk) disable iff (rst)
    (|(flags & irq_en)) |=> irq);
  // R13: with no enabled flag the request drops
  p_irq_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    ((flags & irq_en) == '0) |=> !irq);
endmodule

// File: tb/uart_rx_flags_bench.sv
module uart_rx_flags_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_pin = 1'b1, lb_txd = 1'b1, lb_en = 1'b0, rx_inv = 1'b0;
  logic        mode9 = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic [12:0] baud_div = 13'd1;
  logic [7:0]  flag_clr = 8'h00, irq_en = 8'h00;
  logic [7:0]  rx_data, flags;
  logic        rx_bit8, irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_rx_flags u_uart_rx_flags (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .lb_txd(lb_txd), .lb_en(lb_en),
    .rx_inv(rx_inv), .mode9(mode9), .par_en(par_en), .par_odd(par_odd),
    .baud_div(baud_div), .flag_clr(flag_clr), .irq_en(irq_en),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .flags(flags), .irq(irq)
  );

  typedef struct packed {
    logic       m9, pe, po, inv, lb;
    logic [3:0] div;
    logic       stop;
    logic [3:0] gl;
    logic [8:0] pay;
    logic [7:0] ed;
    logic       eb8;
    logic [7:0] ef;
  } vec_t;

  // flags: bit0 ready, 1 overrun, 2 noise, 3 framing, 4 parity, 5 idle, 6 break, 7 activity
  localparam vec_t VT [14] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd1,1'b1,4'd0,9'h0A5,8'hA5,1'b0,8'h81}, // R1
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'd1,1'b1,4'd0,9'h1C3,8'hC3,1'b1,8'h81}, // R2
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'd1,1'b1,4'd0,9'h003,8'h03,1'b0,8'h81}, // R4 even ok, R2 bit8 back to 0
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'd1,1'b1,4'd0,9'h007,8'h07,1'b0,8'h91}, // R4 even error
    '{1'b0,1'b1,1'b1,1'b0,1'b0,4'd1,1'b1,4'd0,9'h007,8'h07,1'b0,8'h81}, // R4 odd ok
    '{1'b1,1'b1,1'b1,1'b0,1'b0,4'd1,1'b1,4'd0,9'h100,8'h00,1'b1,8'h81}, // R4 9-bit odd ok
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd1,1'b0,4'd0,9'h055,8'h55,1'b0,8'h89}, // R5
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd1,1'b0,4'd0,9'h000,8'h00,1'b0,8'hC9}, // R6
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd1,1'b1,4'd0,9'h03C,8'h3C,1'b0,8'h81}, // R10 invert
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'd1,1'b1,4'd0,9'h096,8'h96,1'b0,8'h81}, // R10 loopback
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd2,1'b1,4'd0,9'h05A,8'h5A,1'b0,8'h81}, // R11 divisor 2
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd1,1'b1,4'd3,9'h00F,8'h0F,1'b0,8'h85}, // R3 noise
    '{1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,1'b1,4'd0,9'h101,8'h01,1'b1,8'h81}, // R4 9-bit even ok
    '{1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,1'b1,4'd0,9'h001,8'h01,1'b0,8'h91}  // R4 9-bit even error
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v);
    if (lb_en) lb_txd = v;
    else       rx_pin = v ^ rx_inv;
  endtask

  task automatic send_bit(input logic lvl, input int cyc, input bit gl);
    for (int k = 0; k < cyc; k++) begin
      drive((gl && k == 8) ? ~lvl : lvl);
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [8:0] pay, input logic m9, input logic stop,
                            input int div, input int gl);
    int cyc;
    int n;
    cyc = 16 * div;
    n = m9 ? 9 : 8;
    send_bit(1'b0, cyc, gl == 0 ? 1'b0 : 1'b0);
    for (int j = 1; j <= n; j++) send_bit(pay[j-1], cyc, gl == j);
    send_bit(stop, cyc, 1'b0);
    drive(1'b1);
  endtask

  task automatic clear_all();
    flag_clr = 8'hFF;
    @(negedge clk);
    flag_clr = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired before completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R14: reset state
    chk("R14 flags after reset", 16'(flags), 16'h00);
    chk("R14 data after reset", {7'd0, rx_bit8, rx_data}, 16'h0);
    chk("R14 irq after reset", 16'(irq), 16'h0);

    for (int i = 0; i < 14; i++) begin
      vec_t v;
      v = VT[i];
      lb_en = v.lb;
      rx_inv = v.inv;
      lb_txd = 1'b1;
      rx_pin = v.lb ? 1'b0 : ~v.inv;
      mode9 = v.m9;
      par_en = v.pe;
      par_odd = v.po;
      baud_div = 13'(v.div);
      repeat (8) @(negedge clk);
      clear_all();
      send_frame(v.pay, v.m9, v.stop, int'(v.div), int'(v.gl));
      repeat (4) @(negedge clk);
      chk($sformatf("R1 R2 data vec%0d", i), 16'(rx_data), 16'(v.ed));
      chk($sformatf("R2 bit8 vec%0d", i), 16'(rx_bit8), 16'(v.eb8));
      chk($sformatf("R3 R4 R5 R6 R9 flags vec%0d", i), 16'(flags), 16'(v.ef));
      repeat (12 * 16 * int'(v.div)) @(negedge clk);
      chk($sformatf("R8 idle vec%0d", i), 16'(flags[5]), 16'h1);
    end

    // back to plain 8-bit operation
    lb_en = 1'b0; rx_inv = 1'b0; rx_pin = 1'b1; lb_txd = 1'b1;
    mode9 = 1'b0; par_en = 1'b0; par_odd = 1'b0; baud_div = 13'd1;
    repeat (8) @(negedge clk);

    // R12: clearing only the ready bit leaves the others (idle, parity, activity)
    flag_clr = 8'h01;
    @(negedge clk);
    flag_clr = 8'h00;
    @(negedge clk);
    chk("R12 single-bit clear", 16'(flags), 16'hB0);
    clear_all();
    chk("R12 clear all", 16'(flags), 16'h00);

    // R7: overrun
    send_frame(9'h011, 1'b0, 1'b1, 1, 0);
    repeat (4) @(negedge clk);
    chk("R1 first frame flags", 16'(flags), 16'h81);
    send_frame(9'h022, 1'b0, 1'b1, 1, 0);
    repeat (4) @(negedge clk);
    chk("R7 overrun flags", 16'(flags), 16'h83);
    chk("R7 data kept", 16'(rx_data), 16'h11);

    // R13: interrupt request
    irq_en = 8'h02;
    repeat (2) @(negedge clk);
    chk("R13 irq with overrun enabled", 16'(irq), 16'h1);
    irq_en = 8'h04;
    repeat (2) @(negedge clk);
    chk("R13 irq with only noise enabled", 16'(irq), 16'h0);
    irq_en = 8'h00;
    repeat (200) @(negedge clk);
    clear_all();

    // R11: zero divisor halts reception; R9 activity still seen
    baud_div = 13'd0;
    repeat (8) @(negedge clk);
    clear_all();
    send_frame(9'h033, 1'b0, 1'b1, 1, 0);
    repeat (4) @(negedge clk);
    chk("R11 R9 no reception with divisor 0", 16'(flags), 16'h80);
    chk("R11 data unchanged", 16'(rx_data), 16'h11);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule